// File: doc/BRIEF.md
# Four-Lane Idle-Column Rate Matcher

This block sits in a four-lane 10G receive path after word alignment and lane deskew. Each cycle of the recovered clock it accepts one column, made of one decoded 9-bit symbol from each of the four lanes. Each cycle of the local reference clock it hands one column onward. A 16-entry buffer of whole columns separates the two clock domains. Write and read pointers cross between the domains in Gray code.

The two clocks differ slightly in frequency. To absorb that difference the block only adds or removes idle columns, in which every lane carries the /R/ code group. The write side discards an incoming idle column when its view of the fill is high. The read side emits the idle column it has just sent a second time when its view of the fill is low. A column in which any lane carries something other than /R/ is never touched. Compensation stays off until every lane reports synchronization and the deskew stage reports the lanes aligned. While it is off, columns flow through unchanged, and the read side starts from a half-full buffer.

Single-cycle event pulses report each removed and each repeated column, one pulse per column. A flag that stays set until reset goes with each kind of pulse.

Top module: `quad_lane_rate_match`

## Requirements
- R1: While either reset is low, `rd_valid`, `ins_pulse`, `del_pulse`, `ins_seen` and `del_seen` are all 0.
- R2: Compensation is armed only while all four `lane_sync` bits and `lanes_aligned` are high. With any of them low, neither `ins_pulse` nor `del_pulse` ever fires.
- R3: After reset, or after the buffer has run empty, the read side outputs nothing until its view of the fill reaches DEPTH/2 (8). The first valid column therefore appears no earlier than 9 and no later than 16 read cycles after reset release. With compensation off, every written column appears once, unmodified and in order.
- R4: Lane l occupies bits [9l+8:9l] of a column. The symbol /R/ is 9'h11C (bit 8 is the control flag). A column is idle only when all four lanes equal 9'h11C.
- R5: When armed, an incoming idle column is discarded, with one `del_pulse` (write clock), whenever the write side sees 12 or more entries buffered.
- R6: When armed, the read side repeats its previous output column, with one `ins_pulse` (read clock), whenever that column was idle and it sees fewer than 4 entries buffered. The repeated column is always idle.
- R7: A column with any non-/R/ lane is never dropped, duplicated, altered or reordered, provided the buffer does not overflow.
- R8: Insertions and deletions repeat as often as needed, with no per-gap limit. With idle columns recurring, the output stays continuous at a ±1% clock offset, far beyond ±100 ppm.
- R9: `ins_seen` / `del_seen` rise with the first insertion / deletion and stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_col | input | 36 | Incoming column, one 9-bit symbol per lane |
| lane_sync | input | 4 | Per-lane synchronization status |
| lanes_aligned | input | 1 | Deskew alignment status |
| rd_clk | input | 1 | Local reference (read) clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| rd_col | output | 36 | Outgoing column |
| rd_valid | output | 1 | `rd_col` holds a column this cycle |
| ins_pulse | output | 1 | One read-clock pulse per repeated idle column |
| ins_seen | output | 1 | Sticky: at least one insertion since reset |
| del_pulse | output | 1 | One write-clock pulse per discarded idle column |
| del_seen | output | 1 | Sticky: at least one deletion since reset |

## Verification
Insertion is the hardest condition to reach from the ports. It needs a low fill as seen through a stale synchronized pointer, and that low fill must coincide with an idle column having just left the buffer. The stimulus gets there by running the read clock 1% fast for thousands of cycles over a stream that has a four-column idle gap every sixteen columns. The fill therefore drifts down into the window while idle columns keep passing through. A second hard case is proving that partial status blocks all compensation. A slow read clock drives the buffer into deletion territory under each of the 31 incomplete combinations of the five status inputs, and no event may appear.

// File: rtl/rm_pkg.sv
`timescale 1ns/1ps
package rm_pkg;
    localparam int LANES = 4;
    localparam int SYM_W = 9;
    localparam int COL_W = LANES * SYM_W;
    localparam logic [SYM_W-1:0] IDLE_SYM = 9'h11C;  // R4: control flag set, code 0x1C

    typedef logic [COL_W-1:0] col_t;

    // R4: a column is idle only when every lane carries the idle symbol
    function automatic logic col_is_idle(col_t c);
        logic r;
        r = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            if (c[l*SYM_W +: SYM_W] != IDLE_SYM) r = 1'b0;
        end
        return r;
    endfunction
endpackage

// File: rtl/rm_sync.sv
`timescale 1ns/1ps
module rm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] src;
        if (s == 0) begin : g_first
            assign src = d;
        end else begin : g_rest
            assign src = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= src;
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rm_col_store.sv
`timescale 1ns/1ps
module rm_col_store
    import rm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  col_t          wdata,
    input  logic [AW-1:0] raddr,
    output col_t          rdata
);
    col_t mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rm_wr_ctrl.sv
`timescale 1ns/1ps
module rm_wr_ctrl
    import rm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AFULL = 12,
    parameter int AW    = 4,
    parameter int PW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  col_t             wr_col,
    input  logic [LANES-1:0] lane_sync,
    input  logic             lanes_aligned,
    input  logic [PW-1:0]    rgray_sync,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [PW-1:0]    wgray,
    output logic             en,
    output logic             del_pulse,
    output logic             del_seen
);
    localparam logic [PW-1:0] DEPTH_W = PW'(DEPTH);
    localparam logic [PW-1:0] AFULL_W = PW'(AFULL);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          en;
        logic          del;
        logic          seen;
    } wr_state_t;

    wr_state_t     st_q, st_d;
    logic [PW-1:0] rbin, fill, bin_inc;
    logic          idle_c, full_c, drop_c, we_c;

    function automatic logic [PW-1:0] gray_to_bin(logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        rbin    = gray_to_bin(rgray_sync);
        fill    = st_q.bin - rbin;
        idle_c  = col_is_idle(wr_col);
        full_c  = (fill >= DEPTH_W);
        drop_c  = st_q.en && idle_c && (fill >= AFULL_W);   // R5
        we_c    = !drop_c && !full_c;
        bin_inc = st_q.bin + PW'(1);

        st_d     = st_q;
        st_d.en  = (&lane_sync) && lanes_aligned;            // R2
        st_d.del = drop_c;
        if (drop_c) st_d.seen = 1'b1;                        // R9
        if (we_c) begin
            st_d.bin  = bin_inc;
            st_d.gray = bin_inc ^ (bin_inc >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we        = we_c;
    assign waddr     = st_q.bin[AW-1:0];
    assign wgray     = st_q.gray;
    assign en        = st_q.en;
    assign del_pulse = st_q.del;
    assign del_seen  = st_q.seen;

    // R5: only an idle column may be discarded
    a_r5_del_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.del |-> $past(idle_c));

    // R2: a deletion needs full status at the ports two cycles earlier
    a_r2_del_gated: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.del |-> $past((&lane_sync) && lanes_aligned, 2));

    // R7: the write side never overruns the read pointer
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH_W);

    // R9: deletion flag is sticky
    a_r9_del_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen |=> st_q.seen);
endmodule

// File: rtl/rm_rd_ctrl.sv
`timescale 1ns/1ps
module rm_rd_ctrl
    import rm_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int AEMPTY = 4,
    parameter int MID    = 8,
    parameter int AW     = 4,
    parameter int PW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wgray_sync,
    input  logic          en_sync,
    input  col_t          rdata,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output col_t          rd_col,
    output logic          rd_valid,
    output logic          ins_pulse,
    output logic          ins_seen
);
    localparam logic [PW-1:0] DEPTH_W  = PW'(DEPTH);
    localparam logic [PW-1:0] AEMPTY_W = PW'(AEMPTY);
    localparam logic [PW-1:0] MID_W    = PW'(MID);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          primed;
        logic          valid;
        logic          ins;
        logic          seen;
        col_t          col;
    } rd_state_t;

    rd_state_t     st_q, st_d;
    logic [PW-1:0] wbin, fill, bin_inc;
    logic          last_idle;

    function automatic logic [PW-1:0] gray_to_bin(logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        wbin      = gray_to_bin(wgray_sync);
        fill      = wbin - st_q.bin;
        last_idle = st_q.valid && col_is_idle(st_q.col);
        bin_inc   = st_q.bin + PW'(1);

        st_d     = st_q;
        st_d.ins = 1'b0;
        if (!st_q.primed) begin
            // R3: hold output until the buffer is half full
            st_d.valid = 1'b0;
            if (fill >= MID_W) st_d.primed = 1'b1;
        end else if (en_sync && last_idle && (fill < AEMPTY_W)) begin
            // R6: repeat the idle column just sent
            st_d.valid = 1'b1;
            st_d.ins   = 1'b1;
            st_d.seen  = 1'b1;
        end else if (fill != '0) begin
            st_d.valid = 1'b1;
            st_d.col   = rdata;
            st_d.bin   = bin_inc;
            st_d.gray  = bin_inc ^ (bin_inc >> 1);
        end else begin
            // R3: ran dry, refill to the midpoint
            st_d.valid  = 1'b0;
            st_d.primed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr     = st_q.bin[AW-1:0];
    assign rgray     = st_q.gray;
    assign rd_col    = st_q.col;
    assign rd_valid  = st_q.valid;
    assign ins_pulse = st_q.ins;
    assign ins_seen  = st_q.seen;

    // R6: an inserted column is the unchanged previous column
    a_r6_ins_repeats: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ins |-> $stable(st_q.col));

    // R6: an inserted column is always idle
    a_r6_ins_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ins |-> col_is_idle(st_q.col));

    // R2: insertion only while the synchronized arm signal is high
    a_r2_ins_gated: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ins |-> $past(en_sync));

    // R3: reads never pass the write pointer
    a_r3_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH_W);

    // R9: insertion flag is sticky
    a_r9_ins_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen |=> st_q.seen);
endmodule

// File: rtl/quad_lane_rate_match.sv
`timescale 1ns/1ps
module quad_lane_rate_match
    import rm_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int AFULL       = 12,
    parameter int AEMPTY      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic [COL_W-1:0] wr_col,
    input  logic [LANES-1:0] lane_sync,
    input  logic             lanes_aligned,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    output logic [COL_W-1:0] rd_col,
    output logic             rd_valid,
    output logic             ins_pulse,
    output logic             ins_seen,
    output logic             del_pulse,
    output logic             del_seen
);
    localparam int AW  = $clog2(DEPTH);
    localparam int PW  = AW + 1;
    localparam int MID = DEPTH / 2;

    logic          we, en_wr, en_rd;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_rd, rgray_wr;
    col_t          rdata;

    rm_wr_ctrl #(.DEPTH(DEPTH), .AFULL(AFULL), .AW(AW), .PW(PW)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_col(wr_col),
        .lane_sync(lane_sync), .lanes_aligned(lanes_aligned),
        .rgray_sync(rgray_wr), .we(we), .waddr(waddr), .wgray(wgray),
        .en(en_wr), .del_pulse(del_pulse), .del_seen(del_seen)
    );

    rm_col_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_col),
        .raddr(raddr), .rdata(rdata)
    );

    rm_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_rd)
    );

    rm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_en (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(en_wr), .q(en_rd)
    );

    rm_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_wr)
    );

    rm_rd_ctrl #(.DEPTH(DEPTH), .AEMPTY(AEMPTY), .MID(MID), .AW(AW), .PW(PW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .wgray_sync(wgray_rd), .en_sync(en_rd),
        .rdata(rdata), .raddr(raddr), .rgray(rgray), .rd_col(rd_col),
        .rd_valid(rd_valid), .ins_pulse(ins_pulse), .ins_seen(ins_seen)
    );
endmodule

// File: tb/quad_lane_rate_match_bench.sv
`timescale 1ns/1ps
module quad_lane_rate_match_bench;
    localparam int LN = 4;
    localparam int SW = 9;
    localparam int CW = LN * SW;
    localparam logic [SW-1:0] KR = 9'h11C;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b1, rd_rst_n = 1'b1;
    logic [CW-1:0] wr_col = '0;
    logic [3:0]    lane_sync = '0;
    logic          lanes_aligned = 1'b0;
    logic [CW-1:0] rd_col;
    logic          rd_valid, ins_pulse, ins_seen, del_pulse, del_seen;

    real rd_half = 10.0;
    int  checks = 0, errors = 0;
    bit  done = 1'b0, strict = 1'b0;
    int  rcyc, first_valid, mj, mk, data_errs, gaps, ins_cnt, ins_bad, del_cnt;

    quad_lane_rate_match u_quad_lane_rate_match (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_col(wr_col),
        .lane_sync(lane_sync), .lanes_aligned(lanes_aligned),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_col(rd_col),
        .rd_valid(rd_valid), .ins_pulse(ins_pulse), .ins_seen(ins_seen),
        .del_pulse(del_pulse), .del_seen(del_seen)
    );

    always #10 wr_clk = ~wr_clk;   // 50 MHz
    initial begin
        #3;
        forever #(rd_half) rd_clk = ~rd_clk;
    end

    // data column k: lane 0 always data, other lanes idle when k%3==0 (R4/R7)
    function automatic logic [CW-1:0] gen(int k);
        logic [CW-1:0] c;
        for (int l = 0; l < LN; l++) begin
            if ((k % 3) == 0 && l != 0) c[l*SW +: SW] = KR;
            else                        c[l*SW +: SW] = {1'b0, 8'((k * 4 + l) % 256)};
        end
        return c;
    endfunction

    // stream: 12 data columns then 4 idle columns, repeating
    function automatic logic [CW-1:0] col_of(int j);
        if ((j % 16) >= 12) return {LN{KR}};
        return gen((j / 16) * 12 + (j % 16));
    endfunction

    function automatic bit is_idle(logic [CW-1:0] c);
        return c == {LN{KR}};
    endfunction

    // writer
    logic wr_live = 1'b0;
    int   wj = 0;
    always @(posedge wr_clk) wr_live <= wr_rst_n;
    always @(negedge wr_clk) begin
        if (!wr_live) wj = 0;
        else          wj = wj + 1;
        wr_col = col_of(wj);
    end

    // output monitor
    always @(negedge rd_clk) begin
        if (rd_rst_n) begin
            rcyc = rcyc + 1;
            if (ins_pulse) begin
                ins_cnt = ins_cnt + 1;
                if (!is_idle(rd_col)) ins_bad = ins_bad + 1;
            end
            if (rd_valid) begin
                if (first_valid < 0) first_valid = rcyc;
                if (strict) begin
                    if (rd_col !== col_of(mj)) data_errs = data_errs + 1;
                    mj = mj + 1;
                end else if (!is_idle(rd_col)) begin
                    if (rd_col !== gen(mk)) data_errs = data_errs + 1;
                    mk = mk + 1;
                end
            end else if (first_valid >= 0) begin
                gaps = gaps + 1;
            end
        end
    end

    always @(negedge wr_clk) if (wr_rst_n && del_pulse) del_cnt = del_cnt + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset(input logic [4:0] m, input real h, input bit s);
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        rd_half = h;
        lane_sync = m[3:0];
        lanes_aligned = m[4];
        strict = s;
        rcyc = 0; first_valid = -1; mj = 0; mk = 0; data_errs = 0; gaps = 0;
        ins_cnt = 0; ins_bad = 0; del_cnt = 0;
        repeat (4) @(negedge wr_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
    endtask

    task automatic reset_state_checks(input string tag);
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (3) @(negedge wr_clk);
        check(rd_valid == 1'b0, "R1", {tag, " rd_valid"}, int'(rd_valid), 0);
        check(ins_pulse == 1'b0 && del_pulse == 1'b0, "R1", {tag, " pulses"},
              int'(ins_pulse) + int'(del_pulse), 0);
        check(ins_seen == 1'b0 && del_seen == 1'b0, "R9", {tag, " sticky cleared"},
              int'(ins_seen) + int'(del_seen), 0);
    endtask

    initial begin
        #1;
        reset_state_checks("power-up");

        // R2: every incomplete status combination, slow reader pushes toward deletion
        for (int m = 0; m < 31; m++) begin
            do_reset(5'(m), 11.0, 1'b0);
            repeat (300) @(negedge wr_clk);
            check(ins_cnt + del_cnt == 0, "R2", $sformatf("status mask %0d events", m),
                  ins_cnt + del_cnt, 0);
        end

        // R3: compensation off, equal clocks, exact pass-through
        do_reset(5'b01111, 10.0, 1'b1);
        repeat (2000) @(negedge wr_clk);
        check(first_valid >= 9 && first_valid <= 16, "R3", "midpoint priming latency",
              first_valid, 12);
        check(data_errs == 0, "R3", "unmodified in-order stream", data_errs, 0);
        check(mj > 1500, "R3", "columns delivered", mj, 1900);
        check(gaps == 0, "R3", "continuous output", gaps, 0);
        check(ins_cnt + del_cnt == 0, "R2", "no events while disarmed", ins_cnt + del_cnt, 0);

        // R5/R8: armed, reader 1% slow
        do_reset(5'b11111, 10.1, 1'b0);
        repeat (6000) @(negedge wr_clk);
        check(data_errs == 0, "R7", "data columns intact under deletion", data_errs, 0);
        check(mk > 4000, "R7", "data columns delivered", mk, 4400);
        check(del_cnt >= 20, "R5", "repeated deletions", del_cnt, 59);
        check(ins_cnt == 0, "R6", "no insertion while fill rises", ins_cnt, 0);
        check(gaps == 0, "R8", "no gap under slow reader", gaps, 0);
        check(del_seen == 1'b1, "R9", "del_seen set", int'(del_seen), 1);
        repeat (2) @(negedge wr_clk);
        check(del_seen == 1'b1, "R9", "del_seen holds", int'(del_seen), 1);

        reset_state_checks("after deletion run");

        // R6/R8: armed, reader 1% fast
        do_reset(5'b11111, 9.9, 1'b0);
        repeat (6000) @(negedge wr_clk);
        check(data_errs == 0, "R7", "data columns intact under insertion", data_errs, 0);
        check(ins_cnt >= 20, "R6", "repeated insertions", ins_cnt, 60);
        check(ins_bad == 0, "R6", "inserted columns idle", ins_bad, 0);
        check(gaps == 0, "R8", "no underrun under fast reader", gaps, 0);
        check(ins_seen == 1'b1, "R9", "ins_seen set", int'(ins_seen), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule